// File: doc/BRIEF.md
# Timer control and status register pair

This block holds the two 32-bit configuration and status words of a processor timer unit. The control word is written whole by software. It carries the period selections, the reset-control code and the interrupt enables. These fields are sent to the counting logic next to this block. The status word collects sticky event flags raised by three timer sources: the decrementer, the fixed-interval timer and the watchdog. It also holds two watchdog-state fields that the watchdog counter sets.

Software clears status flags by writing ones to the matching bit positions. Hardware set events take priority over those clears. When the processor resumes from a halt, the watchdog state is wiped so that a stale expiry does not act at once.

Each source has a level interrupt output. The output is registered and equals the AND of the source's status flag and its enable bit in the control word, as they stood in the previous cycle.

Top module: `tmr_csr`

## Requirements
- R1: While `rst_ni` is low, the control word, the status word and all three interrupt outputs are zero. This holds at once, without waiting for a clock edge.
- R2: A control write replaces every implemented control bit with the written value. The implemented bits are 31:22 and 20:13. Bits 21 and 12:0 always read zero. With `HAS_EXT`=0, bits 20:13 also read zero.
- R3: The control layout is as follows. Watchdog period is bits 31:30 and watchdog reset control is 29:28. Watchdog enable is bit 27, decrementer enable is bit 26 and fixed-interval enable is bit 23. Fixed-interval period is 25:24 and auto-reload is bit 22. The watchdog period extension is 20:17 and the fixed-interval extension is 16:13. `wdg_period_o` is {bits 20:17, bits 31:30} and `fit_period_o` is {bits 16:13, bits 25:24}.
- R4: A one-cycle pulse sets a status bit, which then stays set. `dec_evt_i` sets bit 27, `fit_evt_i` sets bit 26 and `wdg_evt_i` sets bit 30. `wdg_enw_set_i` sets bit 31. `wdg_rst_set_i` ORs into bits 29:28. A status bit is never set without its event.
- R5: A status write clears each status bit where the written data is one and leaves the others unchanged.
- R6: When a set event and a clear (by a status write or by resume) hit the same status bit in one cycle, the bit ends up set.
- R7: A `resume_i` pulse clears status bits 31:28. Bits 27 and 26 are kept.
- R8: Each interrupt output follows one cycle behind its status AND enable pair. `dec_irq_o` is bit 27 AND control bit 26. `fit_irq_o` is bit 26 AND control bit 23. `wdg_irq_o` is bit 30 AND control bit 27.
- R9: Status bits 25:0 always read zero.
- R10: A control write leaves the status word unchanged. The control word changes only on a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control write data |
| ctl_rdata_o | output | 32 | Control word readback |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | 32 | Status clear mask |
| sts_rdata_o | output | 32 | Status word readback |
| dec_evt_i | input | 1 | Decrementer event pulse |
| fit_evt_i | input | 1 | Fixed-interval event pulse |
| wdg_evt_i | input | 1 | Watchdog interrupt event pulse |
| wdg_enw_set_i | input | 1 | Sets the enable-next-watchdog flag |
| wdg_rst_set_i | input | 2 | Bits ORed into watchdog reset status |
| resume_i | input | 1 | Processor leaves halt; clears watchdog state |
| wdg_period_o | output | 6 | Watchdog period select with extension |
| fit_period_o | output | 6 | Fixed-interval period select with extension |
| wdg_rst_ctl_o | output | 2 | Watchdog reset control code |
| auto_reload_o | output | 1 | Decrementer auto-reload enable |
| dec_irq_o | output | 1 | Decrementer interrupt |
| fit_irq_o | output | 1 | Fixed-interval interrupt |
| wdg_irq_o | output | 1 | Watchdog interrupt |

## Verification
The assertions check the following on every cycle:
- each interrupt follows its status and enable bits from the previous cycle;
- an event always leaves its flag set, and no flag rises without its event;
- a clear-only status write leaves no written-one bit set;
- a clean resume empties the watchdog fields;
- the reserved bits stay zero, and the control word holds between writes.

Only the bench scenarios can show the following:
- the field positions behind the decoded period outputs;
- the set-over-clear priority when a pulse meets a write or a resume;
- the exact cycle in which an interrupt drops after a clear;
- the asynchronous wipe of both words.

// File: rtl/tmr_csr_pkg.sv
package tmr_csr_pkg;
  localparam int CSR_W = 32;
  localparam int N_SRC = 3;

  // interrupt source index
  localparam int SRC_DEC = 0;
  localparam int SRC_FIT = 1;
  localparam int SRC_WDG = 2;

  // control word positions (decoded by neighbouring counters)
  localparam int CTL_WDG_PER_LO = 30;
  localparam int CTL_WDG_RST_LO = 28;
  localparam int CTL_WDG_IE     = 27;
  localparam int CTL_DEC_IE     = 26;
  localparam int CTL_FIT_PER_LO = 24;
  localparam int CTL_FIT_IE     = 23;
  localparam int CTL_AUTO_RLD   = 22;
  localparam int CTL_WDG_EXT_LO = 17;
  localparam int CTL_FIT_EXT_LO = 13;
  localparam int EXT_W          = 4;
  localparam int PER_W          = 2;

  // status word positions
  localparam int STS_ENW    = 31;
  localparam int STS_WIS    = 30;
  localparam int STS_WRS_LO = 28;
  localparam int STS_DIS    = 27;
  localparam int STS_FIS    = 26;

  localparam logic [CSR_W-1:0] CTL_BASE_MASK = 32'hFFC0_0000;
  localparam logic [CSR_W-1:0] CTL_EXT_MASK  = 32'h001F_E000;
  localparam logic [CSR_W-1:0] STS_IMPL_MASK = 32'hFC00_0000;
  localparam logic [CSR_W-1:0] STS_WDG_MASK  = 32'hF000_0000;

  function automatic logic [CSR_W-1:0] ctl_wmask(input bit has_ext);
    return has_ext ? (CTL_BASE_MASK | CTL_EXT_MASK) : CTL_BASE_MASK;
  endfunction
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_csr_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] q_o,
  output logic [EXT_W+PER_W-1:0] wdg_period_o,
  output logic [EXT_W+PER_W-1:0] fit_period_o,
  output logic [1:0]       wdg_rst_ctl_o,
  output logic             auto_reload_o
);
  localparam logic [CSR_W-1:0] WMASK = ctl_wmask(HAS_EXT);

  logic [CSR_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & WMASK;
  end

  assign q_o           = q;
  assign wdg_rst_ctl_o = q[CTL_WDG_RST_LO +: 2];
  assign auto_reload_o = q[CTL_AUTO_RLD];

  generate
    if (HAS_EXT) begin : g_ext
      assign wdg_period_o = {q[CTL_WDG_EXT_LO +: EXT_W], q[CTL_WDG_PER_LO +: PER_W]};
      assign fit_period_o = {q[CTL_FIT_EXT_LO +: EXT_W], q[CTL_FIT_PER_LO +: PER_W]};
    end else begin : g_noext
      assign wdg_period_o = {{EXT_W{1'b0}}, q[CTL_WDG_PER_LO +: PER_W]};
      assign fit_period_o = {{EXT_W{1'b0}}, q[CTL_FIT_PER_LO +: PER_W]};
    end
  endgenerate
endmodule

// File: rtl/tmr_sts_reg.sv
module tmr_sts_reg
  import tmr_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             resume_i,
  input  logic [CSR_W-1:0] set_i,
  output logic [CSR_W-1:0] q_o
);
  logic [CSR_W-1:0] q, clr, nxt;

  always_comb begin
    clr = '0;
    if (we_i)     clr = clr | wdata_i;
    if (resume_i) clr = clr | STS_WDG_MASK;
    // set after clear: a same-cycle event is never lost
    nxt = ((q & ~clr) | set_i) & STS_IMPL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[i] <= 1'b0;
      else         irq_o[i] <= sts_i[i] & en_i[i];
    end
  end
endmodule

// File: rtl/tmr_csr.sv
module tmr_csr
  import tmr_csr_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_we_i,
  input  logic [31:0] ctl_wdata_i,
  output logic [31:0] ctl_rdata_o,
  input  logic        sts_we_i,
  input  logic [31:0] sts_wdata_i,
  output logic [31:0] sts_rdata_o,
  input  logic        dec_evt_i,
  input  logic        fit_evt_i,
  input  logic        wdg_evt_i,
  input  logic        wdg_enw_set_i,
  input  logic [1:0]  wdg_rst_set_i,
  input  logic        resume_i,
  output logic [5:0]  wdg_period_o,
  output logic [5:0]  fit_period_o,
  output logic [1:0]  wdg_rst_ctl_o,
  output logic        auto_reload_o,
  output logic        dec_irq_o,
  output logic        fit_irq_o,
  output logic        wdg_irq_o
);
  logic [CSR_W-1:0] ctl_q, sts_q, sts_set;
  logic [N_SRC-1:0] src_sts, src_en, src_irq;

  tmr_ctl_reg #(.HAS_EXT(HAS_EXT)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (ctl_we_i),
    .wdata_i       (ctl_wdata_i),
    .q_o           (ctl_q),
    .wdg_period_o  (wdg_period_o),
    .fit_period_o  (fit_period_o),
    .wdg_rst_ctl_o (wdg_rst_ctl_o),
    .auto_reload_o (auto_reload_o)
  );

  always_comb begin
    sts_set                       = '0;
    sts_set[STS_ENW]              = wdg_enw_set_i;
    sts_set[STS_WIS]              = wdg_evt_i;
    sts_set[STS_WRS_LO +: 2]      = wdg_rst_set_i;
    sts_set[STS_DIS]              = dec_evt_i;
    sts_set[STS_FIS]              = fit_evt_i;
  end

  tmr_sts_reg u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (sts_we_i),
    .wdata_i  (sts_wdata_i),
    .resume_i (resume_i),
    .set_i    (sts_set),
    .q_o      (sts_q)
  );

  always_comb begin
    src_sts[SRC_DEC] = sts_q[STS_DIS];
    src_sts[SRC_FIT] = sts_q[STS_FIS];
    src_sts[SRC_WDG] = sts_q[STS_WIS];
    src_en[SRC_DEC]  = ctl_q[CTL_DEC_IE];
    src_en[SRC_FIT]  = ctl_q[CTL_FIT_IE];
    src_en[SRC_WDG]  = ctl_q[CTL_WDG_IE];
  end

  tmr_irq_gate #(.N(N_SRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_i  (src_sts),
    .en_i   (src_en),
    .irq_o  (src_irq)
  );

  assign ctl_rdata_o = ctl_q;
  assign sts_rdata_o = sts_q;
  assign dec_irq_o   = src_irq[SRC_DEC];
  assign fit_irq_o   = src_irq[SRC_FIT];
  assign wdg_irq_o   = src_irq[SRC_WDG];
endmodule

// File: rtl/tmr_csr_chk.sv
module tmr_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_we_i,
  input logic [31:0] ctl_rdata_o,
  input logic        sts_we_i,
  input logic [31:0] sts_wdata_i,
  input logic [31:0] sts_rdata_o,
  input logic        dec_evt_i,
  input logic        fit_evt_i,
  input logic        wdg_evt_i,
  input logic        wdg_enw_set_i,
  input logic [1:0]  wdg_rst_set_i,
  input logic        resume_i,
  input logic        dec_irq_o,
  input logic        fit_irq_o,
  input logic        wdg_irq_o
);
  logic no_set;
  assign no_set = !dec_evt_i && !fit_evt_i && !wdg_evt_i && !wdg_enw_set_i && (wdg_rst_set_i == 2'b00);

  a_r8_dec_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dec_irq_o == ($past(sts_rdata_o[27]) & $past(ctl_rdata_o[26])));
  a_r8_fit_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fit_irq_o == ($past(sts_rdata_o[26]) & $past(ctl_rdata_o[23])));
  a_r8_wdg_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> wdg_irq_o == ($past(sts_rdata_o[30]) & $past(ctl_rdata_o[27])));
  a_r4_dec_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_evt_i |=> sts_rdata_o[27]);
  a_r4_wdg_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_evt_i |=> sts_rdata_o[30]);
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_evt_i |=> !$rose(sts_rdata_o[27]));
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && no_set) |=> (sts_rdata_o & $past(sts_wdata_i)) == 32'h0);
  a_r7_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && no_set) |=> sts_rdata_o[31:28] == 4'h0);
  a_r9_sts_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rdata_o[25:0] == 26'h0);
  a_r2_ctl_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[21] == 1'b0) && (ctl_rdata_o[12:0] == 13'h0));
  a_r10_ctl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(ctl_rdata_o));
endmodule

bind tmr_csr tmr_csr_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctl_we_i      (ctl_we_i),
  .ctl_rdata_o   (ctl_rdata_o),
  .sts_we_i      (sts_we_i),
  .sts_wdata_i   (sts_wdata_i),
  .sts_rdata_o   (sts_rdata_o),
  .dec_evt_i     (dec_evt_i),
  .fit_evt_i     (fit_evt_i),
  .wdg_evt_i     (wdg_evt_i),
  .wdg_enw_set_i (wdg_enw_set_i),
  .wdg_rst_set_i (wdg_rst_set_i),
  .resume_i      (resume_i),
  .dec_irq_o     (dec_irq_o),
  .fit_irq_o     (fit_irq_o),
  .wdg_irq_o     (wdg_irq_o)
);

// File: tb/tmr_csr_tb.sv
module tmr_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic [31:0] ctl_rdata_o;
  logic        sts_we_i = 1'b0;
  logic [31:0] sts_wdata_i = '0;
  logic [31:0] sts_rdata_o;
  logic        dec_evt_i = 1'b0, fit_evt_i = 1'b0, wdg_evt_i = 1'b0;
  logic        wdg_enw_set_i = 1'b0;
  logic [1:0]  wdg_rst_set_i = 2'b00;
  logic        resume_i = 1'b0;
  logic [5:0]  wdg_period_o, fit_period_o;
  logic [1:0]  wdg_rst_ctl_o;
  logic        auto_reload_o, dec_irq_o, fit_irq_o, wdg_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  tmr_csr u_dut (.*);

  // evt / irq order: {wdg, dec, fit}
  typedef struct packed {
    logic [31:0] ctl;
    logic [2:0]  evt;
    logic [2:0]  irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0000, 3'b111, 3'b000},
    '{32'h0400_0000, 3'b010, 3'b010},
    '{32'h0800_0000, 3'b111, 3'b100},
    '{32'h0080_0000, 3'b001, 3'b001},
    '{32'h0C80_0000, 3'b101, 3'b101},
    '{32'h0C80_0000, 3'b000, 3'b000},
    '{32'h0880_0000, 3'b111, 3'b101},
    '{32'hFFFF_FFFF, 3'b111, 3'b111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk_i); ctl_we_i = 1'b0;
  endtask

  task automatic wr_sts(input logic [31:0] v);
    @(negedge clk_i); sts_we_i = 1'b1; sts_wdata_i = v;
    @(negedge clk_i); sts_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] evt, input logic enw, input logic [1:0] wrs);
    @(negedge clk_i);
    {wdg_evt_i, dec_evt_i, fit_evt_i} = evt;
    wdg_enw_set_i = enw; wdg_rst_set_i = wrs;
    @(negedge clk_i);
    {wdg_evt_i, dec_evt_i, fit_evt_i} = 3'b000;
    wdg_enw_set_i = 1'b0; wdg_rst_set_i = 2'b00;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20;
    check("R1 ctl", ctl_rdata_o, 32'h0);
    check("R1 sts", sts_rdata_o, 32'h0);
    check("R1 irq", {29'h0, wdg_irq_o, dec_irq_o, fit_irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // table walk (R8, R4)
    foreach (VECS[i]) begin
      wr_sts(32'hFFFF_FFFF);
      wr_ctl(VECS[i].ctl);
      pulse(VECS[i].evt, 1'b0, 2'b00);
      @(negedge clk_i);
      check("R4 flags", {29'h0, sts_rdata_o[30], sts_rdata_o[27], sts_rdata_o[26]}, {29'h0, VECS[i].evt});
      check("R8 irq", {29'h0, wdg_irq_o, dec_irq_o, fit_irq_o}, {29'h0, VECS[i].irq});
    end

    // R2 / R3 field layout
    wr_ctl(32'hFFFF_FFFF);
    check("R2 mask", ctl_rdata_o, 32'hFFDF_E000);
    wr_ctl(32'h7254_6000);
    check("R2 overwrite", ctl_rdata_o, 32'h7254_6000);
    check("R3 wdg_period", {26'h0, wdg_period_o}, 32'h29);
    check("R3 fit_period", {26'h0, fit_period_o}, 32'h0E);
    check("R3 rst_ctl", {30'h0, wdg_rst_ctl_o}, 32'h3);
    check("R3 auto_reload", {31'h0, auto_reload_o}, 32'h1);

    // R4 / R9 all status sources
    wr_sts(32'hFFFF_FFFF);
    pulse(3'b111, 1'b1, 2'b11);
    check("R4 all set", sts_rdata_o, 32'hFC00_0000);
    repeat (3) @(negedge clk_i);
    check("R4 sticky", sts_rdata_o, 32'hFC00_0000);

    // R10 control write leaves status
    wr_ctl(32'h0000_0000);
    check("R10 sts kept", sts_rdata_o, 32'hFC00_0000);

    // R5 partial clear
    wr_sts(32'h4000_0000);
    check("R5 w1c bit30", sts_rdata_o, 32'hBC00_0000);
    wr_sts(32'h0400_0000);
    check("R5 w1c bit26", sts_rdata_o, 32'hB800_0000);

    // R7 resume keeps 27/26
    pulse(3'b111, 1'b1, 2'b11);
    @(negedge clk_i); resume_i = 1'b1;
    @(negedge clk_i); resume_i = 1'b0;
    check("R7 resume", sts_rdata_o, 32'h0C00_0000);

    // R6 set wins against resume
    @(negedge clk_i); resume_i = 1'b1; wdg_evt_i = 1'b1;
    @(negedge clk_i); resume_i = 1'b0; wdg_evt_i = 1'b0;
    check("R6 resume vs set", sts_rdata_o, 32'h4C00_0000);

    // R6 set wins against write clear
    wr_sts(32'hFFFF_FFFF);
    @(negedge clk_i); sts_we_i = 1'b1; sts_wdata_i = 32'h0C00_0000; dec_evt_i = 1'b1;
    @(negedge clk_i); sts_we_i = 1'b0; dec_evt_i = 1'b0;
    check("R6 w1c vs set", sts_rdata_o, 32'h0800_0000);

    // R8 exact timing
    wr_sts(32'hFFFF_FFFF);
    wr_ctl(32'h0400_0000);
    pulse(3'b010, 1'b0, 2'b00);
    check("R8 flag now", {31'h0, sts_rdata_o[27]}, 32'h1);
    check("R8 irq lags", {31'h0, dec_irq_o}, 32'h0);
    @(negedge clk_i);
    check("R8 irq rise", {31'h0, dec_irq_o}, 32'h1);
    wr_sts(32'h0800_0000);
    check("R8 irq still", {31'h0, dec_irq_o}, 32'h1);
    @(negedge clk_i);
    check("R8 irq drop", {31'h0, dec_irq_o}, 32'h0);

    // R1 asynchronous reset mid-run
    wr_ctl(32'hFFFF_FFFF);
    pulse(3'b111, 1'b0, 2'b00);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async ctl", ctl_rdata_o, 32'h0);
    check("R1 async sts", sts_rdata_o, 32'h0);
    check("R1 async irq", {29'h0, wdg_irq_o, dec_irq_o, fit_irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule